// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block holds the eight event flags of a combined I2C and clocked-serial interface in one byte that the CPU can read. The serial engine reports events as single-cycle strobes: buffer transfers, frame positions, sampled SDA and SCL levels, and address compare inputs. The block turns each strobe into a sticky flag. Two flags change meaning with the frame format. In I2C format, bit 2 reports lost arbitration and bit 6 is tied to the 9th clock. In clocked-serial format, bit 2 reports receive overrun and bit 6 is tied to the last transmitted bit.

Software clears a flag in two steps. It must first read the flag as 1 and then write 0 to that bit. A write of 0 to a flag that was not read as 1 since the previous write leaves the flag unchanged. Accesses to the data buffers also clear flags as a side effect. A write to the transmit data register clears the transmit-empty and transmit-end flags. A read of the receive data register clears the receive-full flag. When a hardware set and any clear of the same flag fall in the same cycle, the set takes effect.

Top module: `i2c_stat_reg`

## Requirements
- R1: While reset is asserted, and at the first read after reset, all eight status bits are 0.
- R2: The status byte has this layout: b7 transmit-empty, b6 transmit-end, b5 receive-full, b4 no-acknowledge, b3 stop, b2 arbitration-lost or overrun, b1 address match, b0 general call.
- R3: A status write clears a bit only if all three hold: the bit was 1 when the status was read, that read came after the previous status write, and the written data bit is 0. A written 1 never changes a flag.
- R4: Each status write consumes the read arming of every bit. A second write of 0 with no read in between clears nothing.
- R5: The receive-full flag (b5) sets on a receive buffer transfer strobe. It clears on a CPU read of the receive data register.
- R6: The transmit-empty flag (b7) sets on any one of four strobes: transmit buffer load, transmit mode select, start or repeated-start generation, or a switch from slave receive to slave transmit.
- R7: A CPU write to the transmit data register clears b7 and b6.
- R8: In I2C format (fmt_ser = 0), b6 sets on the 9th-clock strobe only while b7 is 1. In clocked-serial format (fmt_ser = 1), b6 sets on the last-transmitted-bit strobe.
- R9: In I2C format, b2 sets in either of two cases. The first is master transmit with a rising SCL while the driven SDA value differs from the SDA pin. The second is master mode with a start detected while the SDA pin is 1.
- R10: In clocked-serial format, b2 sets when the last-received-bit strobe arrives while b5 is 1. It does not set while b5 is 0.
- R11: The no-acknowledge flag (b4) sets on the no-acknowledge strobe only while ack_en is 1.
- R12: In I2C format, during slave receive, an address-frame strobe sets b1 when rx_addr equals own_addr, and sets b0 when rx_addr equals the all-zero general call address.
- R13: The stop flag (b3) sets on a detected stop only if a 9th-clock strobe came after the most recent start or stop.
- R14: A hardware set of a flag overrides a software clear or a buffer-access clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_ser | input | 1 | 1 selects clocked-serial format, 0 selects I2C |
| ack_en | input | 1 | Acknowledge checking enable |
| ev_tx_load | input | 1 | Transmit data register moved into the shift register |
| ev_tx_mode | input | 1 | Transmit mode selected |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_rx2tx | input | 1 | Slave receive changed to slave transmit |
| ev_scl9 | input | 1 | 9th SCL clock of an I2C frame |
| ev_last_tx | input | 1 | Last bit of a clocked-serial frame sent |
| ev_rx_xfer | input | 1 | Receive shift register moved into the receive data register |
| ev_last_rx | input | 1 | Last bit of a clocked-serial item received |
| ev_nack | input | 1 | No acknowledge seen after transmission |
| ev_stop | input | 1 | Stop condition detected |
| ev_start_det | input | 1 | Start condition detected on the bus |
| mst_tx | input | 1 | Master transmit mode |
| mst_mode | input | 1 | Master mode (transmit or receive) |
| scl_rise | input | 1 | Rising SCL edge strobe |
| sda_drv | input | 1 | SDA value being driven |
| sda_pin | input | 1 | Sampled SDA pin level |
| slv_rx | input | 1 | Slave receive mode |
| ev_addr_frame | input | 1 | First frame after a start completed |
| rx_addr | input | ADDR_W | Received address |
| own_addr | input | ADDR_W | Programmed slave address |
| cpu_rd_stat | input | 1 | CPU reads the status register |
| cpu_wr_stat | input | 1 | CPU writes the status register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd_rxd | input | 1 | CPU reads the receive data register |
| cpu_wr_txd | input | 1 | CPU writes the transmit data register |
| status | output | 8 | Current flag byte |

## Verification
If a bit's arming state is wrong, the error appears at the port only at the next status write. That write then clears a flag that should have stayed set, or keeps a flag that should have been cleared. The status output shows the result one cycle after the write. A stale frame-seen state in the stop logic stays hidden until the next stop strobe, and then b3 shows the wrong value one cycle later. A wrong format selection shows one cycle after a last-bit or 9th-clock strobe, because the wrong source then drives b2 or b6.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
   localparam int unsigned NFLAG = 8;
   typedef logic [NFLAG-1:0] flag_t;

   // bit positions of the status byte
   localparam int unsigned F_TXE = 7;
   localparam int unsigned F_TND = 6;
   localparam int unsigned F_RXF = 5;
   localparam int unsigned F_NAK = 4;
   localparam int unsigned F_STP = 3;
   localparam int unsigned F_ARB = 2;
   localparam int unsigned F_ADM = 1;
   localparam int unsigned F_GCA = 0;

   // side-effect clears caused by data buffer access
   function automatic flag_t buf_clear_mask(input logic wr_txd, input logic rd_rxd);
      flag_t m;
      m = '0;
      m[F_TXE] = wr_txd;
      m[F_TND] = wr_txd;
      m[F_RXF] = rd_rxd;
      return m;
   endfunction
endpackage

// File: rtl/i2c_stat_cell.sv
module i2c_stat_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic sw_rd,
   input  logic sw_wr,
   input  logic sw_wbit,
   output logic q,
   output logic arm
);
   logic sw_clr;
   assign sw_clr = sw_wr & arm & ~sw_wbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= 1'b0;
         arm <= 1'b0;
      end else begin
         if (hw_set)
            q <= 1'b1;
         else if (hw_clr || sw_clr)
            q <= 1'b0;
         if (sw_wr)
            arm <= 1'b0;
         else if (sw_rd)
            arm <= q;
      end
   end
endmodule

// File: rtl/i2c_stat_evt.sv
module i2c_stat_evt
   import i2c_stat_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned GC_ADDR   = 0,
   parameter bit          SERIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_ser,
   input  logic              ack_en,
   input  logic              ev_tx_load,
   input  logic              ev_tx_mode,
   input  logic              ev_start_gen,
   input  logic              ev_rx2tx,
   input  logic              ev_scl9,
   input  logic              ev_last_tx,
   input  logic              ev_rx_xfer,
   input  logic              ev_last_rx,
   input  logic              ev_nack,
   input  logic              ev_stop,
   input  logic              ev_start_det,
   input  logic              mst_tx,
   input  logic              mst_mode,
   input  logic              scl_rise,
   input  logic              sda_drv,
   input  logic              sda_pin,
   input  logic              slv_rx,
   input  logic              ev_addr_frame,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] own_addr,
   input  flag_t             cur,
   output flag_t             setv
);
   localparam logic [ADDR_W-1:0] GC_VAL = GC_ADDR[ADDR_W-1:0];

   logic ser;
   logic frame_seen;
   logic arb_i2c, ovr_ser, adr_win;

   generate
      if (SERIAL_EN) begin : g_fmt_sel
         assign ser = fmt_ser;
      end else begin : g_fmt_fixed
         logic unused_fmt;
         assign unused_fmt = fmt_ser;
         assign ser = 1'b0;
      end
   endgenerate

   // a frame has completed since the last start or stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_seen <= 1'b0;
      else if (ev_scl9)
         frame_seen <= 1'b1;
      else if (ev_stop || ev_start_det)
         frame_seen <= 1'b0;
   end

   assign arb_i2c = (mst_tx & scl_rise & (sda_drv ^ sda_pin))
                  | (mst_mode & ev_start_det & sda_pin);
   assign ovr_ser = ev_last_rx & cur[F_RXF];
   assign adr_win = ~ser & slv_rx & ev_addr_frame;

   always_comb begin
      setv        = '0;
      setv[F_TXE] = ev_tx_load | ev_tx_mode | ev_start_gen | ev_rx2tx;
      setv[F_TND] = ser ? ev_last_tx : (ev_scl9 & cur[F_TXE]);
      setv[F_RXF] = ev_rx_xfer;
      setv[F_NAK] = ev_nack & ack_en;
      setv[F_STP] = ev_stop & frame_seen;
      setv[F_ARB] = ser ? ovr_ser : arb_i2c;
      setv[F_ADM] = adr_win & (rx_addr == own_addr);
      setv[F_GCA] = adr_win & (rx_addr == GC_VAL);
   end
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
   import i2c_stat_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned GC_ADDR   = 0,
   parameter bit          SERIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_ser,
   input  logic              ack_en,
   input  logic              ev_tx_load,
   input  logic              ev_tx_mode,
   input  logic              ev_start_gen,
   input  logic              ev_rx2tx,
   input  logic              ev_scl9,
   input  logic              ev_last_tx,
   input  logic              ev_rx_xfer,
   input  logic              ev_last_rx,
   input  logic              ev_nack,
   input  logic              ev_stop,
   input  logic              ev_start_det,
   input  logic              mst_tx,
   input  logic              mst_mode,
   input  logic              scl_rise,
   input  logic              sda_drv,
   input  logic              sda_pin,
   input  logic              slv_rx,
   input  logic              ev_addr_frame,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              cpu_rd_stat,
   input  logic              cpu_wr_stat,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_rd_rxd,
   input  logic              cpu_wr_txd,
   output logic [7:0]        status
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_aw
         $error("i2c_stat_reg: ADDR_W must lie in 1..10");
      end
      if (GC_ADDR >= (1 << ADDR_W)) begin : g_bad_gc
         $error("i2c_stat_reg: GC_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   flag_t flags, arm_q, set_vec, clr_vec;

   assign clr_vec = buf_clear_mask(cpu_wr_txd, cpu_rd_rxd);

   i2c_stat_evt #(
      .ADDR_W   (ADDR_W),
      .GC_ADDR  (GC_ADDR),
      .SERIAL_EN(SERIAL_EN)
   ) u_evt (
      .clk          (clk),
      .rst_n        (rst_n),
      .fmt_ser      (fmt_ser),
      .ack_en       (ack_en),
      .ev_tx_load   (ev_tx_load),
      .ev_tx_mode   (ev_tx_mode),
      .ev_start_gen (ev_start_gen),
      .ev_rx2tx     (ev_rx2tx),
      .ev_scl9      (ev_scl9),
      .ev_last_tx   (ev_last_tx),
      .ev_rx_xfer   (ev_rx_xfer),
      .ev_last_rx   (ev_last_rx),
      .ev_nack      (ev_nack),
      .ev_stop      (ev_stop),
      .ev_start_det (ev_start_det),
      .mst_tx       (mst_tx),
      .mst_mode     (mst_mode),
      .scl_rise     (scl_rise),
      .sda_drv      (sda_drv),
      .sda_pin      (sda_pin),
      .slv_rx       (slv_rx),
      .ev_addr_frame(ev_addr_frame),
      .rx_addr      (rx_addr),
      .own_addr     (own_addr),
      .cur          (flags),
      .setv         (set_vec)
   );

   for (genvar i = 0; i < NFLAG; i++) begin : g_cell
      i2c_stat_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (set_vec[i]),
         .hw_clr (clr_vec[i]),
         .sw_rd  (cpu_rd_stat),
         .sw_wr  (cpu_wr_stat),
         .sw_wbit(cpu_wdata[i]),
         .q      (flags[i]),
         .arm    (arm_q[i])
      );
   end

   assign status = flags;
endmodule

// File: rtl/i2c_stat_chk.sv
module i2c_stat_chk
   import i2c_stat_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status,
   input flag_t      arm,
   input flag_t      setv,
   input logic       cpu_wr_stat,
   input logic       cpu_rd_rxd,
   input logic       cpu_wr_txd,
   input logic       ack_en
);
   // R1: flags held at zero during reset
   always @(posedge clk) begin
      if (!rst_n)
         a_r1_reset_zero: assert (status == 8'h00);
   end

   // R3: unarmed set bits survive a status write
   a_r3_unarmed_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_stat && !cpu_wr_txd && !cpu_rd_rxd)
      |=> ((status & $past(status & ~arm)) == $past(status & ~arm)));

   // R4: every write consumes the arming
   a_r4_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_stat |=> (arm == '0));

   // R5: receive data read clears receive-full
   a_r5_rxd_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_rxd && !setv[F_RXF]) |=> !status[F_RXF]);

   // R7: transmit data write clears empty and end
   a_r7_txd_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_txd && !setv[F_TXE] && !setv[F_TND]) |=> (status[F_TXE:F_TND] == 2'b00));

   // R11: no-ack stays low while acknowledge checking is off
   a_r11_nak_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_en && !status[F_NAK]) |=> !status[F_NAK]);

   // R14: a hardware set always lands
   a_r14_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|setv) |=> ((status & $past(setv)) == $past(setv)));
endmodule

bind i2c_stat_reg i2c_stat_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .status     (status),
   .arm        (arm_q),
   .setv       (set_vec),
   .cpu_wr_stat(cpu_wr_stat),
   .cpu_rd_rxd (cpu_rd_rxd),
   .cpu_wr_txd (cpu_wr_txd),
   .ack_en     (ack_en)
);

// File: tb/sim_i2c_stat_reg.sv
`timescale 1ns/1ps
module sim_i2c_stat_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fmt_ser = 0, ack_en = 0;
   logic ev_tx_load = 0, ev_tx_mode = 0, ev_start_gen = 0, ev_rx2tx = 0;
   logic ev_scl9 = 0, ev_last_tx = 0, ev_rx_xfer = 0, ev_last_rx = 0;
   logic ev_nack = 0, ev_stop = 0, ev_start_det = 0;
   logic mst_tx = 0, mst_mode = 0, scl_rise = 0, sda_drv = 0, sda_pin = 0;
   logic slv_rx = 0, ev_addr_frame = 0;
   logic [6:0] rx_addr = '0, own_addr = 7'h2A;
   logic cpu_rd_stat = 0, cpu_wr_stat = 0, cpu_rd_rxd = 0, cpu_wr_txd = 0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] status;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   i2c_stat_reg u0 (.*);

   // {fmt_ser, ack_en, tx_load, tx_mode, start_gen, rx2tx, scl9, last_tx,
   //  rx_xfer, last_rx, nack, stop, start_det} then expected status
   localparam int NV = 9;
   localparam logic [20:0] VEC [NV] = '{
      21'h000200,  // R13 stop with no frame
      21'h004000,  // R8 9th clock while empty is 0
      21'h020080,  // R6 transmit mode
      21'h0040C0,  // R8 9th clock while empty is 1
      21'h0010E0,  // R5 receive transfer
      21'h0004E0,  // R11 nack, checking off
      21'h0804F0,  // R11 nack, checking on
      21'h0002F8,  // R13 stop after frame
      21'h1008FC   // R10 overrun in serial format
   };

   task automatic tick();
      @(negedge clk);
      {ev_tx_load, ev_tx_mode, ev_start_gen, ev_rx2tx, ev_scl9, ev_last_tx} = '0;
      {ev_rx_xfer, ev_last_rx, ev_nack, ev_stop, ev_start_det} = '0;
      {scl_rise, ev_addr_frame, cpu_rd_stat, cpu_wr_stat, cpu_rd_rxd, cpu_wr_txd} = '0;
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      checks++;
      if (status !== exp) begin
         errors++;
         $display("FAIL %s status=%h expected=%h", req, status, exp);
      end
   endtask

   task automatic sw_clear();
      cpu_rd_stat = 1; tick();
      cpu_wr_stat = 1; cpu_wdata = 8'h00; tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 8'h00);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset", 8'h00);

      for (int i = 0; i < NV; i++) begin
         {fmt_ser, ack_en, ev_tx_load, ev_tx_mode, ev_start_gen, ev_rx2tx, ev_scl9,
          ev_last_tx, ev_rx_xfer, ev_last_rx, ev_nack, ev_stop, ev_start_det} = VEC[i][20:8];
         tick();
         chk($sformatf("R2 vector %0d", i), VEC[i][7:0]);
      end
      fmt_ser = 0; ack_en = 0;

      // R3 unarmed write of 0
      cpu_wr_stat = 1; cpu_wdata = 8'h00; tick();
      chk("R3 unarmed write", 8'hFC);
      cpu_rd_stat = 1; tick();
      cpu_wr_stat = 1; cpu_wdata = 8'h7F; tick();
      chk("R3 armed write clears only zero bit", 8'h7C);
      cpu_wr_stat = 1; cpu_wdata = 8'h00; tick();
      chk("R4 second write without read", 8'h7C);
      sw_clear();
      chk("R3 read then write clears", 8'h00);

      // R6 / R7
      ev_tx_load = 1; tick(); chk("R6 tx load", 8'h80);
      cpu_wr_txd = 1; tick(); chk("R7 txd write", 8'h00);
      ev_start_gen = 1; tick(); chk("R6 start gen", 8'h80);
      ev_scl9 = 1; tick(); chk("R8 tend set", 8'hC0);
      cpu_wr_txd = 1; tick(); chk("R7 txd write clears both", 8'h00);
      ev_rx2tx = 1; tick(); chk("R6 rx to tx", 8'h80);
      cpu_wr_txd = 1; tick();

      // R5 / R14
      ev_rx_xfer = 1; tick(); chk("R5 rx set", 8'h20);
      ev_rx_xfer = 1; cpu_rd_rxd = 1; tick(); chk("R14 set over buffer clear", 8'h20);
      cpu_rd_rxd = 1; tick(); chk("R5 rxd read", 8'h00);
      ev_rx_xfer = 1; tick();
      cpu_rd_stat = 1; tick();
      cpu_wr_stat = 1; cpu_wdata = 8'h00; ev_rx_xfer = 1; tick();
      chk("R14 set over software clear", 8'h20);
      cpu_rd_rxd = 1; tick();

      // R8 / R10 serial format
      fmt_ser = 1;
      ev_last_rx = 1; tick(); chk("R10 no overrun when empty", 8'h00);
      ev_last_tx = 1; tick(); chk("R8 serial tend", 8'h40);
      cpu_wr_txd = 1; tick();
      fmt_ser = 0;

      // R9 arbitration
      mst_tx = 1; scl_rise = 1; sda_drv = 1; sda_pin = 1; tick();
      chk("R9 matching SDA", 8'h00);
      scl_rise = 1; sda_drv = 0; tick();
      chk("R9 SDA mismatch", 8'h04);
      mst_tx = 0; sw_clear();
      mst_mode = 1; ev_start_det = 1; sda_pin = 1; tick();
      chk("R9 start with SDA high", 8'h04);
      sw_clear();
      ev_start_det = 1; sda_pin = 0; tick();
      chk("R9 start with SDA low", 8'h00);
      mst_mode = 0;

      // R12 addresses
      slv_rx = 1; rx_addr = 7'h2A; ev_addr_frame = 1; tick();
      chk("R12 own address", 8'h02);
      sw_clear();
      rx_addr = 7'h00; ev_addr_frame = 1; tick();
      chk("R12 general call", 8'h01);
      sw_clear();
      rx_addr = 7'h15; ev_addr_frame = 1; tick();
      chk("R12 other address", 8'h00);
      slv_rx = 0; rx_addr = 7'h2A; ev_addr_frame = 1; tick();
      chk("R12 not slave receive", 8'h00);

      // R13 start cancels frame
      ev_scl9 = 1; tick();
      ev_start_det = 1; tick();
      ev_stop = 1; tick();
      chk("R13 stop after start only", 8'h00);
      ev_scl9 = 1; tick();
      ev_stop = 1; tick();
      chk("R13 stop after frame", 8'h08);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule